// File: doc/BRIEF.md
# Instruction Store Programming Port

This block lets a host load an instruction store one word at a time. Each word is 42 bits wide: 40 bits of instruction and 2 parity bits. The host works through a small register window. One register holds an enable flag and the store location to write next. A second register holds the low 32 bits of a word being assembled. Writing the remaining high bits to a third register commits the whole word and moves the location forward. When the location passes the last word it wraps back to zero.

On the execution side, a fetch port reads words back through a valid/ready request channel and a valid/ready response channel. When checking is switched on, each fetched word has its two parity bits recomputed and compared. Any mismatch is reported with that response and also sets a sticky error flag.

With GEN_PARITY at 0, the parity bits the host supplies are stored unchanged, so the host can place deliberately wrong parity in the store. With GEN_PARITY at 1, the block computes both parity bits itself as each word is committed.

Top module: `cstore_wport`

## Requirements
- R1: After reset the location reads 0, the enable flag and the check flag are clear, the sticky error flag is low, no response is pending, and fetch_ready is high.
- R2: A write to offset 0x000 loads the enable flag from bit 31 and the location from bits [IDXW-1:0]; the other bits are dropped. A read returns the enable flag in bit 31, the location in its low bits, and zeros elsewhere.
- R3: A write to offset 0x004 captures word bits [31:0] into a holding register. It commits nothing and leaves the location unchanged.
- R4: A write to offset 0x008 takes word bits [41:32] from write-data bits [9:0] and ignores bits [31:10]. It stores the assembled word at the current location and advances the location by one.
- R5: A commit at location DEPTH-1 wraps the location to 0, so with the enable flag set the index register then reads exactly 0x80000000.
- R6: While the enable flag is clear, writes to 0x004 and 0x008 change neither the store nor the location.
- R7: With GEN_PARITY=1, stored bit 40 is the XOR of instruction bits [19:0] and stored bit 41 is the XOR of bits [39:20] (even parity per half). The host-supplied bits are discarded.
- R8: A fetch is accepted on a cycle where fetch_valid and fetch_ready are both high. The word at that address appears on rsp_word with rsp_valid one cycle later, and stays unchanged while rsp_ready is low. fetch_ready equals !rsp_valid || rsp_ready.
- R9: When bit 28 of offset 0x018 was set at the time a fetch was accepted, rsp_perr is raised if either stored parity bit disagrees with the one recomputed from the fetched instruction bits. When bit 28 was clear, rsp_perr stays low.
- R10: perr_flag goes high after a response with rsp_perr is delivered. It stays high until a write to offset 0x018 clears it; if a new error is delivered in the same cycle as that write, the flag stays set.
- R11: Offset 0x018 reads back the check flag in bit 28 and zeros in every other bit. Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 12 | Register byte offset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request ready |
| fetch_addr | input | IDXW | Store location to fetch |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_ready | input | 1 | Fetch response ready |
| rsp_word | output | 42 | Fetched word including its parity bits |
| rsp_perr | output | 1 | Parity mismatch on this response |
| perr_flag | output | 1 | Sticky parity-error flag |

## Verification
The bench builds two instances with DEPTH=16, so that sixteen commits are enough to reach the location wrap and the exact 0x80000000 readback. One instance uses GEN_PARITY=0. It stores host parity with deliberate single-bit errors in each half, which drives the mismatch detection, the sticky flag and its clearing. The second instance shares the same stimulus with GEN_PARITY=1. Its fetched words show that the block computes parity on its own and that those words never raise an error.

// File: rtl/cstore_pkg.sv
package cstore_pkg;
  localparam int WORD_W     = 42;
  localparam int INSN_W     = 40;
  localparam int HALF_W     = 20;
  localparam int HOST_AW    = 12;
  localparam int HOST_DW    = 32;
  localparam int UPPER_BITS = WORD_W - HOST_DW;
  localparam int EN_BIT     = 31;
  localparam int CHK_BIT    = 28;

  localparam logic [HOST_AW-1:0] OFF_INDEX = 12'h000;
  localparam logic [HOST_AW-1:0] OFF_LOWER = 12'h004;
  localparam logic [HOST_AW-1:0] OFF_UPPER = 12'h008;
  localparam logic [HOST_AW-1:0] OFF_CTRL  = 12'h018;

  typedef logic [WORD_W-1:0] word_t;

  // {parity of high half, parity of low half}; XOR gives even parity
  function automatic logic [1:0] parity_pair(input logic [INSN_W-1:0] insn);
    return {^insn[INSN_W-1:HALF_W], ^insn[HALF_W-1:0]};
  endfunction

  function automatic logic parity_bad(input word_t w);
    return parity_pair(w[INSN_W-1:0]) != w[WORD_W-1:INSN_W];
  endfunction
endpackage

// File: rtl/cstore_regs.sv
module cstore_regs
  import cstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDXW  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               prog_en,
  output logic [IDXW-1:0]    wr_idx,
  output logic               chk_en,
  output logic               ctrl_wr,
  output logic               commit,
  output word_t              commit_word
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

  logic [HOST_DW-1:0] lo_hold;
  logic sel_index, sel_lower, sel_upper, sel_ctrl;

  assign sel_index = host_addr == OFF_INDEX;
  assign sel_lower = host_addr == OFF_LOWER;
  assign sel_upper = host_addr == OFF_UPPER;
  assign sel_ctrl  = host_addr == OFF_CTRL;

  assign commit      = host_wr && sel_upper && prog_en;
  assign ctrl_wr     = host_wr && sel_ctrl;
  assign commit_word = {host_wdata[UPPER_BITS-1:0], lo_hold};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_en <= 1'b0;
      wr_idx  <= '0;
      chk_en  <= 1'b0;
      lo_hold <= '0;
    end else if (host_wr) begin
      if (sel_index) begin
        prog_en <= host_wdata[EN_BIT];
        wr_idx  <= host_wdata[IDXW-1:0];
      end
      if (sel_lower && prog_en) lo_hold <= host_wdata;
      if (commit) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      if (sel_ctrl) chk_en <= host_wdata[CHK_BIT];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (sel_index) begin
      host_rdata[EN_BIT]     = prog_en;
      host_rdata[IDXW-1:0]   = wr_idx;
    end else if (sel_lower) begin
      host_rdata = lo_hold;
    end else if (sel_ctrl) begin
      host_rdata[CHK_BIT] = chk_en;
    end
  end
endmodule

// File: rtl/cstore_array.sv
module cstore_array
  import cstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDXW  = 10
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_addr,
  input  word_t           wr_word,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_addr,
  output word_t           rd_word
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/cstore_fetch.sv
module cstore_fetch
  import cstore_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fetch_valid,
  output logic  fetch_ready,
  input  logic  chk_en,
  input  logic  ctrl_wr,
  output logic  rd_en,
  input  word_t rd_word,
  output logic  rsp_valid,
  input  logic  rsp_ready,
  output logic  rsp_perr,
  output logic  perr_flag
);
  logic chk_q;
  logic deliver_bad;

  assign fetch_ready = !rsp_valid || rsp_ready;
  assign rd_en       = fetch_valid && fetch_ready;
  assign rsp_perr    = rsp_valid && chk_q && parity_bad(rd_word);
  assign deliver_bad = rsp_valid && rsp_ready && rsp_perr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      chk_q     <= 1'b0;
      perr_flag <= 1'b0;
    end else begin
      if (fetch_ready) rsp_valid <= fetch_valid;
      if (rd_en) chk_q <= chk_en;
      if (deliver_bad) perr_flag <= 1'b1;
      else if (ctrl_wr) perr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cstore_wport.sv
module cstore_wport
  import cstore_pkg::*;
#(
  parameter int  DEPTH      = 1024,
  parameter bit  GEN_PARITY = 1'b0,
  localparam int IDXW       = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [IDXW-1:0]    fetch_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_word,
  output logic               rsp_perr,
  output logic               perr_flag
);
  logic            prog_en, chk_en, ctrl_wr, commit, rd_en;
  logic [IDXW-1:0] wr_idx;
  word_t           commit_word, store_word, rd_word;

  cstore_regs #(.DEPTH(DEPTH), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .prog_en(prog_en),
    .wr_idx(wr_idx), .chk_en(chk_en), .ctrl_wr(ctrl_wr), .commit(commit),
    .commit_word(commit_word)
  );

  generate
    if (GEN_PARITY) begin : g_par_gen
      assign store_word = {parity_pair(commit_word[INSN_W-1:0]), commit_word[INSN_W-1:0]};
    end else begin : g_par_host
      assign store_word = commit_word;
    end
  endgenerate

  cstore_array #(.DEPTH(DEPTH), .IDXW(IDXW)) u_array (
    .clk(clk), .wr_en(commit), .wr_addr(wr_idx), .wr_word(store_word),
    .rd_en(rd_en), .rd_addr(fetch_addr), .rd_word(rd_word)
  );

  cstore_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .chk_en(chk_en), .ctrl_wr(ctrl_wr), .rd_en(rd_en), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_perr(rsp_perr),
    .perr_flag(perr_flag)
  );

  assign rsp_word = rd_word;
endmodule

// File: rtl/cstore_wport_chk.sv
module cstore_wport_chk
  import cstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDXW  = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_wr,
  input logic               prog_en,
  input logic [IDXW-1:0]    wr_idx,
  input logic               chk_en,
  input logic               fetch_valid,
  input logic               fetch_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [WORD_W-1:0]  rsp_word,
  input logic               rsp_perr,
  input logic               perr_flag
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

  assert_idx_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFF_UPPER && prog_en) |=>
      wr_idx == (($past(wr_idx) == LAST_IDX) ? '0 : $past(wr_idx) + 1'b1));

  assert_idx_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != OFF_INDEX && !prog_en) |=> $stable(wr_idx) && !prog_en);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_word) && $stable(rsp_perr));

  assert_no_chk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !chk_en) |=> !rsp_perr);

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_perr) |=> perr_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !(host_wr && host_addr == OFF_CTRL)) |=> perr_flag);
endmodule

bind cstore_wport cstore_wport_chk #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .prog_en(prog_en), .wr_idx(wr_idx), .chk_en(chk_en),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_perr(rsp_perr),
  .perr_flag(perr_flag)
);

// File: tb/cstore_wport_bench.sv
module cstore_wport_bench;
  localparam int DEPTH = 16;
  localparam int IDXW  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] host_addr = '0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, g_rdata;
  logic        fetch_valid = 1'b0;
  logic [IDXW-1:0] fetch_addr = '0;
  logic        fetch_ready, g_fetch_ready;
  logic        rsp_valid, g_rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [41:0] rsp_word, g_rsp_word;
  logic        rsp_perr, g_rsp_perr, perr_flag, g_perr_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [42:0] exp_q[$];
  logic [41:0] model [DEPTH];

  always #10 clk = ~clk;

  cstore_wport #(.DEPTH(DEPTH), .GEN_PARITY(1'b0)) u_cstore_wport (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_perr(rsp_perr),
    .perr_flag(perr_flag)
  );

  cstore_wport #(.DEPTH(DEPTH), .GEN_PARITY(1'b1)) u_cstore_wport_gen (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(g_rdata), .fetch_valid(fetch_valid),
    .fetch_ready(g_fetch_ready), .fetch_addr(fetch_addr), .rsp_valid(g_rsp_valid),
    .rsp_ready(rsp_ready), .rsp_word(g_rsp_word), .rsp_perr(g_rsp_perr),
    .perr_flag(g_perr_flag)
  );

  function automatic logic [41:0] good_word(input logic [39:0] insn);
    logic p_lo, p_hi;
    p_lo = 1'b0; p_hi = 1'b0;
    for (int b = 0; b < 20; b++) begin
      p_lo = p_lo ^ insn[b];
      p_hi = p_hi ^ insn[b+20];
    end
    return {p_hi, p_lo, insn};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #2;
    host_wr = 1'b0;
  endtask

  task automatic hcheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(posedge clk); #2;
    host_addr = a;
    #1 check(tag, host_rdata, exp);
  endtask

  // driver: queue the expected response, then hold the request until accepted
  task automatic do_fetch(input int a, input logic perr_exp);
    @(posedge clk); #2;
    fetch_valid = 1'b1;
    fetch_addr = IDXW'(a);
    exp_q.push_back({perr_exp, model[a]});
    do @(negedge clk); while (!fetch_ready);
    @(posedge clk); #2;
    fetch_valid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  // monitor: compare every delivered response with the head of the queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        logic [42:0] e;
        e = exp_q.pop_front();
        check("R8 fetched word", 64'(rsp_word), 64'(e[41:0]));
        check("R9 response parity flag", 64'(rsp_perr), 64'(e[42]));
        check("R7 generated-parity word", 64'(g_rsp_word), 64'(good_word(e[39:0])));
        check("R7 generated-parity no error", 64'(g_rsp_perr), 64'd0);
      end
    end
  end

  function automatic logic [41:0] make_word(input int i);
    logic [39:0] insn;
    logic [41:0] w;
    insn = 40'(64'h12_3456_789A * 64'(i + 3)) ^ 40'(i);
    w = good_word(insn);
    if (i == 2) w[40] = ~w[40];
    if (i == 7) w[41] = ~w[41];
    return w;
  endfunction

  task automatic commit_word(input int i, input logic [41:0] w);
    hwrite(12'h004, w[31:0]);
    hwrite(12'h008, {22'h2D5A3C, w[41:32]});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    hcheck("R1 index after reset", 12'h000, 32'h0);
    hcheck("R1 ctrl after reset", 12'h018, 32'h0);
    check("R1 perr_flag after reset", 64'(perr_flag), 64'd0);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 fetch_ready after reset", 64'(fetch_ready), 64'd1);

    // R2 index register fields
    hwrite(12'h000, 32'h7FFF_FFF3);
    hcheck("R2 index disabled readback", 12'h000, 32'h0000_0003);
    hwrite(12'h000, 32'hCAFE_0005);
    hcheck("R2 index enabled readback", 12'h000, 32'h8000_0005);

    // R11 control register
    hwrite(12'h018, 32'hFFFF_FFFF);
    hcheck("R11 ctrl only bit 28", 12'h018, 32'h1000_0000);
    hwrite(12'h018, 32'h0);
    hcheck("R11 ctrl cleared", 12'h018, 32'h0);
    hcheck("R11 unmapped offset", 12'h00C, 32'h0);

    // R3 R4 R5 program the whole store from location 0
    hwrite(12'h000, 32'h8000_0000);
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = make_word(i);
      hwrite(12'h004, model[i][31:0]);
      if (i == 0) hcheck("R3 lower write keeps index", 12'h000, 32'h8000_0000);
      hwrite(12'h008, {22'h2D5A3C, model[i][41:32]});
      if (i == DEPTH - 1)
        hcheck("R5 wrap reads 0x80000000", 12'h000, 32'h8000_0000);
      else
        hcheck("R4 index advance", 12'h000, 32'h8000_0000 | 32'(i + 1));
    end

    // R5 wrap again from a mid location
    hwrite(12'h000, 32'h8000_000E);
    model[14] = make_word(40);
    commit_word(14, model[14]);
    model[15] = make_word(41);
    commit_word(15, model[15]);
    hcheck("R5 second wrap", 12'h000, 32'h8000_0000);

    // R6 data writes with programming disabled
    hwrite(12'h000, 32'h0);
    hwrite(12'h004, 32'h1111_1111);
    hwrite(12'h008, 32'h0000_03FF);
    hcheck("R6 index unchanged while disabled", 12'h000, 32'h0);
    hcheck("R6 lower hold unchanged while disabled", 12'h004, model[15][31:0]);

    // R9 checking on, sweep every location (location 0 also covers R6)
    hwrite(12'h018, 32'h1000_0000);
    for (int i = 0; i < DEPTH; i++) do_fetch(i, (i == 2) || (i == 7));
    drain();
    check("R10 flag set after bad word", 64'(perr_flag), 64'd1);
    check("R7 generated flag stays low", 64'(g_perr_flag), 64'd0);
    hwrite(12'h018, 32'h1000_0000);
    #1 check("R10 flag cleared by ctrl write", 64'(perr_flag), 64'd0);

    // R9 checking off
    hwrite(12'h018, 32'h0);
    do_fetch(2, 1'b0);
    do_fetch(7, 1'b0);
    drain();
    check("R9 no flag with checking off", 64'(perr_flag), 64'd0);

    // R8 back-pressure
    hwrite(12'h018, 32'h1000_0000);
    rsp_ready = 1'b0;
    do_fetch(7, 1'b1);
    fork
      do_fetch(5, 1'b0);
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check("R8 response held valid", 64'(rsp_valid), 64'd1);
          check("R8 request stalled", 64'(fetch_ready), 64'd0);
          check("R8 response word stable", 64'(rsp_word), 64'(model[7]));
        end
        @(posedge clk); #2;
        rsp_ready = 1'b1;
      end
    join
    drain();
    check("R10 flag after held bad word", 64'(perr_flag), 64'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule